// File: doc/BRIEF.md
# Register-Write Serial Target with Auto-Increment

This block is a two-wire serial bus target that sits in front of a small file of 8-bit control registers. It oversamples the clock and data lines with a fast system clock, cleans them up, and finds start and stop conditions and clock edges. A write transaction carries a pointer byte and then any number of data bytes. Each data byte lands at the pointer, and the pointer then steps forward, wrapping from the last register back to register 0. A read transaction returns one status byte. That byte carries the external busy flag in its top bit and zeros below it.

Register 0 acts as a command port for a downstream sequencer. Each byte written there is stored and also presented on `cmd_byte_o` together with a one-cycle `cmd_strobe_o`. The strobe is a valid-only stream with no ready: the bus cannot be held off, so the consumer must take the byte in the strobe cycle. The data line is open-drain. The block only asserts `sda_oe_o`, which the pad turns into a low-pulling driver.

Top module: `i2cw_target`

## Requirements
- R1: After reset all registers read 0, `sda_oe_o` is low and `cmd_strobe_o` is low.
- R2: Only the target address 7'b1110010 (bytes sent MSB first, bit 0 of the first byte = 0 for write, 1 for read) is acknowledged. Any other address gets no acknowledge, and the rest of that transaction is ignored until the next start.
- R3: In a write, the first byte after the address loads the register pointer from its low 3 bits, and every later byte is stored at the pointer and acknowledged.
- R4: After a byte is stored at register 7, the pointer moves to register 0.
- R5: A read returns a single byte {busy, 7'b0}. Busy is taken at the SCL falling edge that ends the address acknowledge. After the eighth bit the target releases SDA whatever the master answers.
- R6: The target drives SDA only while SCL is low. It pulls the acknowledge low after the falling edge that ends bit 8 and releases it at the falling edge that ends the ninth clock. It never drives while the master sends bits.
- R7: Storing a byte in register 0 raises `cmd_strobe_o` for exactly one system clock. In that same cycle `cmd_byte_o` equals the byte and register 0 already holds it.
- R8: A start or repeated start in the middle of a byte aborts that byte without storing it and returns the target to address matching.
- R9: A high pulse on SCL lasting one system clock is filtered out and does not count as a bit.
- R10: After a stop the target ignores bus activity until the next start and keeps all stored registers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Serial clock line as seen at the pad |
| sda_i | input | 1 | Serial data line as seen at the pad |
| sda_oe_o | output | 1 | High pulls the data line low |
| busy_i | input | 1 | Busy flag reported in bit 7 of the read byte |
| regs_o | output | 64 | Register file, register n in bits [8n+7:8n] |
| cmd_strobe_o | output | 1 | One-cycle valid for a byte written to register 0 |
| cmd_byte_o | output | 8 | Byte written to register 0, valid with the strobe |

## Verification
The command strobe and the register-file update fall in the same system clock, so the sequencer sees the byte on both paths at once. Bursts start near the top of the file and run through the wrap into register 0. Every strobe cycle is caught on the falling clock edge, and `cmd_byte_o` is compared with register 0 in that cycle. At each stop the bench also checks the number of strobes against its model and compares the whole register file.

// File: rtl/i2cw_pkg.sv
package i2cw_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ADDR_ACK,
    ST_WDATA,
    ST_WACK,
    ST_RDATA,
    ST_RACK
  } xfer_state_t;

  // two-of-three vote
  function automatic logic vote3(input logic [2:0] v);
    return (v[0] & v[1]) | (v[0] & v[2]) | (v[1] & v[2]);
  endfunction

endpackage

// File: rtl/i2cw_line_filter.sv
module i2cw_line_filter #(
  parameter int NLINES      = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NLINES-1:0] raw_i,
  output logic [NLINES-1:0] clean_o
);
  import i2cw_pkg::*;

  for (genvar g = 0; g < NLINES; g++) begin : g_line
    logic [SYNC_STAGES-1:0] sync_q;
    logic [2:0]             hist_q;
    logic                   clean_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        sync_q  <= '1;
        hist_q  <= '1;
        clean_q <= 1'b1;
      end else begin
        sync_q  <= {sync_q[SYNC_STAGES-2:0], raw_i[g]};
        hist_q  <= {hist_q[1:0], sync_q[SYNC_STAGES-1]};
        clean_q <= vote3(hist_q);
      end
    end

    assign clean_o[g] = clean_q;
  end

endmodule

// File: rtl/i2cw_bus_events.sv
module i2cw_bus_events (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_f_i,
  input  logic sda_f_i,
  output logic start_o,
  output logic stop_o,
  output logic rise_o,
  output logic fall_o
);
  logic scl_p_q, sda_p_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_p_q <= 1'b1;
      sda_p_q <= 1'b1;
    end else begin
      scl_p_q <= scl_f_i;
      sda_p_q <= sda_f_i;
    end
  end

  assign start_o = scl_f_i & scl_p_q & sda_p_q & ~sda_f_i;
  assign stop_o  = scl_f_i & scl_p_q & ~sda_p_q & sda_f_i;
  assign rise_o  = scl_f_i & ~scl_p_q;
  assign fall_o  = ~scl_f_i & scl_p_q;

endmodule

// File: rtl/i2cw_regfile.sv
module i2cw_regfile #(
  parameter int NREGS = 8,
  parameter int DW    = 8,
  localparam int AW   = $clog2(NREGS)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en_i,
  input  logic [AW-1:0]       wr_addr_i,
  input  logic [DW-1:0]       wr_data_i,
  output logic [NREGS*DW-1:0] regs_o
);
  for (genvar g = 0; g < NREGS; g++) begin : g_reg
    logic [DW-1:0] val_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        val_q <= '0;
      else if (wr_en_i && wr_addr_i == AW'(g))
        val_q <= wr_data_i;
    end

    assign regs_o[g*DW +: DW] = val_q;
  end

endmodule

// File: rtl/i2cw_target.sv
module i2cw_target #(
  parameter logic [6:0] TARGET_ADDR = 7'b1110010,
  parameter int         NREGS       = 8,
  parameter int         SYNC_STAGES = 2,
  localparam int        BW          = 8,
  localparam int        PW          = $clog2(NREGS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe_o,
  input  logic              busy_i,
  output logic [NREGS*BW-1:0] regs_o,
  output logic              cmd_strobe_o,
  output logic [BW-1:0]     cmd_byte_o
);
  import i2cw_pkg::*;

  localparam logic [3:0]    BYTE_DONE = 4'd8;
  localparam logic [PW-1:0] LAST_REG  = PW'(NREGS - 1);

  logic [1:0] clean;
  logic       scl_lvl, sda_lvl;
  logic       ev_start, ev_stop, ev_rise, ev_fall;

  i2cw_line_filter #(.NLINES(2), .SYNC_STAGES(SYNC_STAGES)) i_filter (
    .clk    (clk),
    .rst_n  (rst_n),
    .raw_i  ({sda_i, scl_i}),
    .clean_o(clean)
  );

  assign scl_lvl = clean[0];
  assign sda_lvl = clean[1];

  i2cw_bus_events i_events (
    .clk    (clk),
    .rst_n  (rst_n),
    .scl_f_i(scl_lvl),
    .sda_f_i(sda_lvl),
    .start_o(ev_start),
    .stop_o (ev_stop),
    .rise_o (ev_rise),
    .fall_o (ev_fall)
  );

  xfer_state_t   state_q;
  logic [3:0]    cnt_q;
  logic [BW-1:0] sh_q;
  logic [BW-2:0] rd_q;
  logic          rw_q;
  logic          have_ptr_q;
  logic [PW-1:0] ptr_q;
  logic          oe_q;
  logic          strobe_q;
  logic [BW-1:0] cmd_q;
  logic          wr_en;
  logic [PW-1:0] ptr_next;

  assign wr_en    = !ev_start && !ev_stop && state_q == ST_WDATA && ev_fall
                    && cnt_q == BYTE_DONE && have_ptr_q;
  assign ptr_next = (ptr_q == LAST_REG) ? '0 : ptr_q + 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= ST_IDLE;
      cnt_q      <= '0;
      sh_q       <= '0;
      rd_q       <= '0;
      rw_q       <= 1'b0;
      have_ptr_q <= 1'b0;
      ptr_q      <= '0;
      oe_q       <= 1'b0;
      strobe_q   <= 1'b0;
      cmd_q      <= '0;
    end else begin
      strobe_q <= 1'b0;
      if (ev_start) begin
        state_q    <= ST_ADDR;
        cnt_q      <= '0;
        oe_q       <= 1'b0;
        have_ptr_q <= 1'b0;
      end else if (ev_stop) begin
        state_q <= ST_IDLE;
        oe_q    <= 1'b0;
      end else begin
        case (state_q)
          ST_ADDR, ST_WDATA: begin
            if (ev_rise) begin
              sh_q  <= {sh_q[BW-2:0], sda_lvl};
              cnt_q <= cnt_q + 1'b1;
            end else if (ev_fall && cnt_q == BYTE_DONE) begin
              cnt_q <= '0;
              if (state_q == ST_ADDR) begin
                if (sh_q[BW-1:1] == TARGET_ADDR) begin
                  oe_q    <= 1'b1;
                  rw_q    <= sh_q[0];
                  state_q <= ST_ADDR_ACK;
                end else begin
                  state_q <= ST_IDLE;
                end
              end else begin
                oe_q    <= 1'b1;
                state_q <= ST_WACK;
                if (!have_ptr_q) begin
                  ptr_q      <= sh_q[PW-1:0];
                  have_ptr_q <= 1'b1;
                end else begin
                  ptr_q <= ptr_next;
                  if (ptr_q == '0) begin
                    strobe_q <= 1'b1;
                    cmd_q    <= sh_q;
                  end
                end
              end
            end
          end
          ST_ADDR_ACK: begin
            if (ev_fall) begin
              if (rw_q) begin
                state_q <= ST_RDATA;
                oe_q    <= ~busy_i;
                rd_q    <= '0;
                cnt_q   <= 4'd1;
              end else begin
                state_q <= ST_WDATA;
                oe_q    <= 1'b0;
              end
            end
          end
          ST_RDATA: begin
            if (ev_fall) begin
              if (cnt_q == BYTE_DONE) begin
                oe_q    <= 1'b0;
                state_q <= ST_RACK;
              end else begin
                oe_q  <= ~rd_q[BW-2];
                rd_q  <= {rd_q[BW-3:0], 1'b0};
                cnt_q <= cnt_q + 1'b1;
              end
            end
          end
          ST_RACK: begin
            if (ev_fall) state_q <= ST_IDLE;
          end
          ST_WACK: begin
            if (ev_fall) begin
              oe_q    <= 1'b0;
              state_q <= ST_WDATA;
              cnt_q   <= '0;
            end
          end
          default: ;
        endcase
      end
    end
  end

  i2cw_regfile #(.NREGS(NREGS), .DW(BW)) i_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en_i  (wr_en),
    .wr_addr_i(ptr_q),
    .wr_data_i(sh_q),
    .regs_o   (regs_o)
  );

  assign sda_oe_o     = oe_q;
  assign cmd_strobe_o = strobe_q;
  assign cmd_byte_o   = cmd_q;

  // R7
  strobe_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_strobe_o |-> regs_o[BW-1:0] == cmd_byte_o);

  // R7
  strobe_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_strobe_o |-> ($past(wr_en) && $past(ptr_q) == '0));

  // R7
  strobe_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_strobe_o |=> !cmd_strobe_o);

  // R4
  ptr_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && ptr_q == LAST_REG) |=> ptr_q == '0);

  // R8
  start_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_start |=> (!sda_oe_o && cnt_q == '0));

  // R6
  oe_scl_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_lvl && $past(scl_lvl)) |-> $stable(sda_oe_o));

endmodule

// File: tb/test_i2cw_target.sv
module test_i2cw_target;
  localparam int Q     = 8;
  localparam int NREGS = 8;
  localparam logic [6:0] TADDR = 7'b1110010;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1, busy = 1'b0;
  logic sda_oe, strobe, sda_line;
  logic [NREGS*8-1:0] regs;
  logic [7:0] cmd_byte;

  assign sda_line = sda_m & ~sda_oe;

  i2cw_target i_i2cw_target (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line),
    .sda_oe_o(sda_oe), .busy_i(busy), .regs_o(regs),
    .cmd_strobe_o(strobe), .cmd_byte_o(cmd_byte)
  );

  int n_vec = 0, n_err = 0;
  int exp_strobes = 0, seen_strobes = 0;
  logic [7:0] exp_regs [NREGS];
  logic strobe_prev = 1'b0;

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_vec++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [63:0] packed_model();
    logic [63:0] p;
    for (int i = 0; i < NREGS; i++) p[i*8 +: 8] = exp_regs[i];
    return p;
  endfunction

  // strobe monitor: R7 co-occurrence of strobe and register update
  always @(negedge clk) begin
    if (rst_n) begin
      if (strobe) begin
        seen_strobes++;
        chk(cmd_byte == regs[7:0], "R7 strobe byte vs reg0", cmd_byte, regs[7:0]);
        chk(!strobe_prev, "R7 strobe width", 1, 0);
      end
      strobe_prev = strobe;
    end
  end

  task automatic send_bit(input logic b, input bit glitch);
    tick(Q);
    if (glitch) begin scl_m = 1'b1; tick(1); scl_m = 1'b0; end
    sda_m = b;
    tick(Q);
    scl_m = 1'b1;
    tick(Q);
    chk(!sda_oe, "R6 no drive during master bit", sda_oe, 0);
    tick(Q);
    scl_m = 1'b0;
  endtask

  task automatic bus_start();
    tick(Q); sda_m = 1'b1; tick(Q); scl_m = 1'b1;
    tick(2*Q); sda_m = 1'b0; tick(2*Q); scl_m = 1'b0;
  endtask

  task automatic bus_stop();
    tick(Q); sda_m = 1'b0; tick(Q); scl_m = 1'b1;
    tick(2*Q); sda_m = 1'b1; tick(2*Q);
  endtask

  task automatic send_byte(input logic [7:0] b, input int glitch_bit,
                           input bit chk_release, output bit acked);
    for (int i = 7; i >= 0; i--) send_bit(b[i], glitch_bit == i);
    tick(Q); sda_m = 1'b1; tick(Q); scl_m = 1'b1; tick(Q);
    acked = (sda_line == 1'b0);
    tick(Q); scl_m = 1'b0;
    if (chk_release) begin
      tick(Q);
      chk(!sda_oe, "R6 release after ninth clock", sda_oe, 0);
    end
  endtask

  task automatic recv_byte(output logic [7:0] b);
    for (int i = 7; i >= 0; i--) begin
      tick(Q); sda_m = 1'b1; tick(Q); scl_m = 1'b1; tick(Q);
      b[i] = sda_line;
      tick(Q); scl_m = 1'b0;
    end
    tick(Q); sda_m = 1'b1; tick(Q); scl_m = 1'b1; tick(2*Q); scl_m = 1'b0;
  endtask

  task automatic check_file(input string req);
    chk(regs == packed_model(), req, regs, packed_model());
    chk(seen_strobes == exp_strobes, "R7 strobe count", seen_strobes, exp_strobes);
  endtask

  // write transaction; returns after stop (and file compare)
  task automatic wr_burst(input logic [6:0] a, input logic [7:0] pb, input int n, input bit glitchy);
    bit ack, want;
    logic [7:0] d;
    logic [2:0] p;
    int gb;
    want = (a == TADDR);
    bus_start();
    send_byte({a, 1'b0}, -1, want, ack);
    chk(ack == want, "R2 address acknowledge", ack, want);
    if (!want) begin
      send_byte(pb, -1, 1'b0, ack);
      chk(!ack, "R2 ignored after foreign address", ack, 0);
    end else begin
      send_byte(pb, -1, 1'b1, ack);
      chk(ack, "R3 pointer byte ack", ack, 1);
      p = pb[2:0];
      for (int k = 0; k < n; k++) begin
        d = 8'($urandom);
        gb = (glitchy && ($urandom % 3 == 0)) ? int'($urandom % 8) : -1;
        send_byte(d, gb, 1'b1, ack);
        chk(ack, "R3 data byte ack", ack, 1);
        exp_regs[p] = d;
        if (p == 3'd0) exp_strobes++;
        p = (p == 3'd7) ? 3'd0 : p + 3'd1;
      end
    end
    bus_stop();
    tick(2*Q);
    check_file("R3 R4 register file after burst");
  endtask

  task automatic rd_status(input logic bz);
    bit ack;
    logic [7:0] b;
    busy = bz;
    bus_start();
    send_byte({TADDR, 1'b1}, -1, 1'b0, ack);
    chk(ack, "R5 read address ack", ack, 1);
    recv_byte(b);
    chk(b == {bz, 7'b0}, "R5 status byte", b, {bz, 7'b0});
    chk(!sda_oe, "R5 released after read", sda_oe, 0);
    bus_stop();
    busy = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_vec++; n_err++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_err);
    $finish;
  end

  initial begin
    bit ack;
    void'($urandom(32'd2718));
    for (int i = 0; i < NREGS; i++) exp_regs[i] = 8'h00;
    tick(5);
    rst_n = 1'b1;
    tick(10);
    // R1
    chk(regs == '0, "R1 registers reset", regs, 0);
    chk(!sda_oe, "R1 sda released", sda_oe, 0);
    chk(!strobe, "R1 no strobe", strobe, 0);

    // R3 simple burst from register 2
    wr_burst(TADDR, 8'h02, 3, 1'b0);
    // R4 wrap through 7 into 0 (also R7 strobe)
    wr_burst(TADDR, 8'h06, 4, 1'b0);
    chk(regs[7:0] == exp_regs[0], "R4 wrapped byte in reg0", regs[7:0], exp_regs[0]);
    // R3 upper pointer bits ignored
    wr_burst(TADDR, 8'hF9, 2, 1'b0);
    // R2 foreign address
    wr_burst(7'h73, 8'h55, 0, 1'b0);
    // R5 both busy values
    rd_status(1'b0);
    rd_status(1'b1);

    // R8 abort mid data byte
    bus_start();
    send_byte({TADDR, 1'b0}, -1, 1'b1, ack);
    send_byte(8'h03, -1, 1'b1, ack);
    send_byte(8'hA5, -1, 1'b1, ack);
    exp_regs[3] = 8'hA5;
    for (int i = 0; i < 4; i++) send_bit(1'b1, 1'b0);
    wr_burst(TADDR, 8'h05, 1, 1'b0);
    chk(regs[4*8 +: 8] == exp_regs[4], "R8 partial byte not stored", regs[4*8 +: 8], exp_regs[4]);
    // R8 abort mid address byte
    bus_start();
    for (int i = 0; i < 3; i++) send_bit(1'b1, 1'b0);
    wr_burst(TADDR, 8'h00, 2, 1'b0);

    // R9 single-cycle SCL glitches inside a byte
    bus_start();
    send_byte({TADDR, 1'b0}, -1, 1'b1, ack);
    send_byte(8'h01, -1, 1'b1, ack);
    send_byte(8'h3C, 5, 1'b1, ack);
    exp_regs[1] = 8'h3C;
    bus_stop();
    tick(2*Q);
    chk(regs[15:8] == 8'h3C, "R9 glitch filtered", regs[15:8], 8'h3C);

    // R10 bytes without a start are ignored
    send_byte({TADDR, 1'b0}, -1, 1'b0, ack);
    chk(!ack, "R10 no ack while idle", ack, 0);
    send_byte(8'h00, -1, 1'b0, ack);
    bus_stop();
    tick(2*Q);
    check_file("R10 registers kept after stop");

    // constrained random mix
    for (int t = 0; t < 16; t++) begin
      int kind;
      logic [6:0] a;
      kind = int'($urandom % 6);
      if (kind == 0) begin
        rd_status(1'($urandom));
      end else if (kind == 1) begin
        a = 7'($urandom);
        if (a == TADDR) a = a ^ 7'h01;
        wr_burst(a, 8'($urandom), 0, 1'b0);
      end else begin
        wr_burst(TADDR, 8'($urandom), 1 + int'($urandom % 9), 1'b1);
      end
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_err);
    $finish;
  end

endmodule